// File: doc/BRIEF.md
# Maskable Interrupt Level Resolver

This block sits between the request storage of a bank of maskable interrupt groups and the processor's interrupt input. Each group supplies four request bits, four enable bits and a 3-bit priority level. Every cycle the block searches the maskable groups (numbers 2 up to the top group), picks the most urgent one that has an enabled pending request, and presents that group's level to the processor from a register. When nothing qualifies, it presents the idle level 7.

When the processor takes an interrupt, it pulses an acknowledge that carries the level it accepted. The block then stores the group number behind the presented level in an accepted-group register. Software reads that register over a small byte bus and gets the group number multiplied by four. If the stored group has since lost its enabled request, the read gives 0 instead. An acknowledge whose level differs from the one on display sets an error flag that stays set until reset.

Top module: `irq_level_resolver`

## Requirements
- R1: With no group in the range 2..NUM_GROUPS-1 having an enabled pending request, `irq_level` is 7 (idle). Groups 0 and 1 never take part, whatever their inputs.
- R2: A group is a candidate when the bitwise AND of its 4 request bits (`req_bits[4g+3:4g]`) and its 4 enable bits (`en_bits[4g+3:4g]`) is nonzero. Its level is `grp_levels[3g+2:3g]`.
- R3: Among candidates, the numerically smallest level wins. On equal levels the lowest group number wins. A candidate at level 7 never displaces the idle choice, so the presented level stays 7 and the winning group stays 0.
- R4: `irq_level` is registered: it reflects the inputs sampled at the previous rising clock edge.
- R5: On a cycle with `ack_valid` high, the accepted-group register loads the group number that belongs to the level presented on `irq_level` in that cycle (0 when idle).
- R6: An acknowledge whose `ack_level` differs from the `irq_level` presented in the same cycle sets `level_err`. Only reset clears it.
- R7: A read (`bus_rd`) at `bus_addr` 0 returns, on `bus_rdata` in the next cycle, the accepted group number shifted left by 2, with bits 1:0 zero.
- R8: That read returns 0 when the accepted group is not a candidate in the read cycle. Reads at any nonzero offset return 0. `bus_rdata` is 0 in every cycle that does not follow a read.
- R9: Writes (`bus_wr`, `bus_wdata`) change no state: later reads and `irq_level` are unaffected.
- R10: After synchronous reset, `irq_level` is 7, `level_err` is 0, `bus_rdata` is 0 and the accepted group is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_bits | input | 4*NUM_GROUPS | Request bits, four per group |
| en_bits | input | 4*NUM_GROUPS | Enable bits, four per group |
| grp_levels | input | 3*NUM_GROUPS | Priority level per group, 0 most urgent |
| ack_valid | input | 1 | Processor accepts an interrupt this cycle |
| ack_level | input | 3 | Level the processor accepted |
| bus_rd | input | 1 | Byte read strobe |
| bus_wr | input | 1 | Byte write strobe (ignored) |
| bus_addr | input | ADDR_W | Byte offset within the accepted-group register |
| bus_wdata | input | 8 | Write data (ignored) |
| bus_rdata | output | 8 | Registered read data |
| irq_level | output | 3 | Registered level presented to the processor |
| level_err | output | 1 | Sticky acknowledge-level mismatch |

## Verification
The properties take for granted that the inputs stay stable between rising edges and that an acknowledge refers to the level being shown in the same cycle. The error property assumes the flag only fails to rise when the two levels agree. The stimulus drives every input half a cycle away from the edge. Most acknowledges copy the presented level back, and a few deliberately flip a bit to exercise the sticky flag. Reads, writes and acknowledges are mixed freely, and the request bits of groups 0 and 1 are toggled as well.

// File: rtl/irq_res_pkg.sv
package irq_res_pkg;
  localparam int LVL_W    = 3;
  localparam int BITS_PER = 4;
  localparam int GID_W    = 5;
  localparam logic [LVL_W-1:0] IDLE_LVL = 3'd7;
endpackage

// File: rtl/irq_cand_mask.sv
module irq_cand_mask #(
  parameter int NUM_GROUPS  = 25,
  parameter int FIRST_GROUP = 2,
  parameter int BITS_PER    = irq_res_pkg::BITS_PER
) (
  input  logic [NUM_GROUPS*BITS_PER-1:0] req_bits,
  input  logic [NUM_GROUPS*BITS_PER-1:0] en_bits,
  output logic [NUM_GROUPS-1:0]          cand
);
  genvar g;
  generate
    for (g = 0; g < NUM_GROUPS; g++) begin : g_grp
      if (g < FIRST_GROUP) begin : g_excl
        assign cand[g] = 1'b0;
      end else begin : g_incl
        assign cand[g] = |(req_bits[g*BITS_PER +: BITS_PER] & en_bits[g*BITS_PER +: BITS_PER]);
      end
    end
  endgenerate
endmodule

// File: rtl/irq_prio_search.sv
module irq_prio_search #(
  parameter int NUM_GROUPS  = 25,
  parameter int FIRST_GROUP = 2,
  parameter int LVL_W       = irq_res_pkg::LVL_W,
  parameter int GID_W       = irq_res_pkg::GID_W
) (
  input  logic [NUM_GROUPS-1:0]       cand,
  input  logic [NUM_GROUPS*LVL_W-1:0] grp_levels,
  output logic [LVL_W-1:0]            best_lvl,
  output logic [GID_W-1:0]            best_gid
);
  always_comb begin
    best_lvl = irq_res_pkg::IDLE_LVL;
    best_gid = '0;
    for (int g = FIRST_GROUP; g < NUM_GROUPS; g++) begin
      if (cand[g] && (grp_levels[g*LVL_W +: LVL_W] < best_lvl)) begin
        best_lvl = grp_levels[g*LVL_W +: LVL_W];
        best_gid = GID_W'(g);
      end
    end
  end
endmodule

// File: rtl/irq_accept_reg.sv
module irq_accept_reg #(
  parameter int NUM_GROUPS = 25,
  parameter int LVL_W      = irq_res_pkg::LVL_W,
  parameter int GID_W      = irq_res_pkg::GID_W,
  parameter int ADDR_W     = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ack_valid,
  input  logic [LVL_W-1:0]      ack_level,
  input  logic [LVL_W-1:0]      shown_lvl,
  input  logic [GID_W-1:0]      shown_gid,
  input  logic [NUM_GROUPS-1:0] cand,
  input  logic                  bus_rd,
  input  logic [ADDR_W-1:0]     bus_addr,
  output logic [7:0]            bus_rdata,
  output logic                  level_err
);
  logic [GID_W-1:0] acc_gid;
  logic             acc_live;
  logic [7:0]       rd_word;

  assign acc_live = (int'(acc_gid) < NUM_GROUPS) ? cand[acc_gid] : 1'b0;
  assign rd_word  = (bus_addr == '0 && acc_live) ? 8'({acc_gid, 2'b00}) : 8'h00;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_gid   <= '0;
      level_err <= 1'b0;
      bus_rdata <= 8'h00;
    end else begin
      if (ack_valid) begin
        acc_gid <= shown_gid;
        if (ack_level != shown_lvl) level_err <= 1'b1;
      end
      bus_rdata <= bus_rd ? rd_word : 8'h00;
    end
  end
endmodule

// File: rtl/irq_level_resolver.sv
module irq_level_resolver #(
  parameter int NUM_GROUPS  = 25,
  parameter int FIRST_GROUP = 2,
  parameter int ADDR_W      = 3,
  localparam int LVL_W      = irq_res_pkg::LVL_W,
  localparam int BITS_PER   = irq_res_pkg::BITS_PER,
  localparam int GID_W      = irq_res_pkg::GID_W
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_GROUPS*BITS_PER-1:0] req_bits,
  input  logic [NUM_GROUPS*BITS_PER-1:0] en_bits,
  input  logic [NUM_GROUPS*LVL_W-1:0]   grp_levels,
  input  logic                          ack_valid,
  input  logic [LVL_W-1:0]              ack_level,
  input  logic                          bus_rd,
  input  logic                          bus_wr,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic [7:0]                    bus_wdata,
  output logic [7:0]                    bus_rdata,
  output logic [LVL_W-1:0]              irq_level,
  output logic                          level_err
);
  logic [NUM_GROUPS-1:0] cand;
  logic [LVL_W-1:0]      best_lvl;
  logic [GID_W-1:0]      best_gid;
  logic [GID_W-1:0]      win_gid_q;
  logic                  unused_inputs;

  // The register is read-only and groups below FIRST_GROUP are excluded.
  assign unused_inputs = ^{bus_wr, bus_wdata,
                           req_bits[FIRST_GROUP*BITS_PER-1:0],
                           en_bits[FIRST_GROUP*BITS_PER-1:0],
                           grp_levels[FIRST_GROUP*LVL_W-1:0]};

  irq_cand_mask #(.NUM_GROUPS(NUM_GROUPS), .FIRST_GROUP(FIRST_GROUP), .BITS_PER(BITS_PER)) u_mask (
    .req_bits(req_bits), .en_bits(en_bits), .cand(cand)
  );

  irq_prio_search #(.NUM_GROUPS(NUM_GROUPS), .FIRST_GROUP(FIRST_GROUP), .LVL_W(LVL_W), .GID_W(GID_W)) u_search (
    .cand(cand), .grp_levels(grp_levels), .best_lvl(best_lvl), .best_gid(best_gid)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_level <= irq_res_pkg::IDLE_LVL;
      win_gid_q <= '0;
    end else begin
      irq_level <= best_lvl;
      win_gid_q <= best_gid;
    end
  end

  irq_accept_reg #(.NUM_GROUPS(NUM_GROUPS), .LVL_W(LVL_W), .GID_W(GID_W), .ADDR_W(ADDR_W)) u_acc (
    .clk(clk), .rst(rst), .ack_valid(ack_valid), .ack_level(ack_level),
    .shown_lvl(irq_level), .shown_gid(win_gid_q), .cand(cand),
    .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_rdata(bus_rdata), .level_err(level_err)
  );
endmodule

// File: rtl/irq_level_resolver_chk.sv
module irq_level_resolver_chk #(
  parameter int NUM_GROUPS  = 25,
  parameter int FIRST_GROUP = 2,
  parameter int ADDR_W      = 3
) (
  input logic                     clk,
  input logic                     rst,
  input logic [NUM_GROUPS*4-1:0]  req_bits,
  input logic [NUM_GROUPS*4-1:0]  en_bits,
  input logic                     ack_valid,
  input logic [2:0]               ack_level,
  input logic                     bus_rd,
  input logic                     bus_wr,
  input logic [ADDR_W-1:0]        bus_addr,
  input logic [7:0]               bus_rdata,
  input logic [2:0]               irq_level,
  input logic                     level_err
);
  logic any_pend;
  always_comb begin
    any_pend = 1'b0;
    for (int g = FIRST_GROUP; g < NUM_GROUPS; g++)
      if ((req_bits[g*4 +: 4] & en_bits[g*4 +: 4]) != 4'h0) any_pend = 1'b1;
  end

  a_r1_idle_level: assert property (@(posedge clk) disable iff (rst)
    !any_pend |=> irq_level == 3'd7);
  a_r6_err_sticky: assert property (@(posedge clk) disable iff (rst)
    level_err |=> level_err);
  a_r6_err_on_mismatch: assert property (@(posedge clk) disable iff (rst)
    (ack_valid && ack_level != irq_level) |=> level_err);
  a_r8_other_offset_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr != '0) |=> bus_rdata == 8'h00);
  a_r9_write_no_data: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !bus_rd) |=> bus_rdata == 8'h00);
  a_r7_low_bits_zero: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rdata[1:0] == 2'b00);
endmodule

bind irq_level_resolver irq_level_resolver_chk #(
  .NUM_GROUPS(NUM_GROUPS), .FIRST_GROUP(FIRST_GROUP), .ADDR_W(ADDR_W)
) u_chk (.*);

// File: tb/test_irq_level_resolver.sv
`timescale 1ns/1ps
module test_irq_level_resolver;
  localparam int NG = 25;
  localparam int FG = 2;
  localparam int AW = 3;

  logic clk = 0;
  logic rst = 1;
  logic [3:0] rq [NG];
  logic [3:0] en [NG];
  logic [2:0] lv [NG];
  logic [NG*4-1:0] req_bits, en_bits;
  logic [NG*3-1:0] grp_levels;
  logic ack_valid = 0, bus_rd = 0, bus_wr = 0;
  logic [2:0] ack_level = 0;
  logic [AW-1:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata;
  logic [2:0] irq_level;
  logic level_err;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  always_comb
    for (int g = 0; g < NG; g++) begin
      req_bits[g*4 +: 4]   = rq[g];
      en_bits[g*4 +: 4]    = en[g];
      grp_levels[g*3 +: 3] = lv[g];
    end

  irq_level_resolver #(.NUM_GROUPS(NG), .FIRST_GROUP(FG), .ADDR_W(AW)) i_irq_level_resolver (
    .clk(clk), .rst(rst), .req_bits(req_bits), .en_bits(en_bits), .grp_levels(grp_levels),
    .ack_valid(ack_valid), .ack_level(ack_level), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_level(irq_level), .level_err(level_err)
  );

  // Behavioural reference, advanced on each rising edge
  int m_lvl = 7, m_gid = 0, m_acc = 0, m_err = 0, m_rd = 0;

  function automatic bit is_cand(int g);
    if (g < FG || g >= NG) return 0;
    return (rq[g] & en[g]) != 0;
  endfunction

  always @(posedge clk) begin
    int bl, bg, rdv;
    if (rst) begin
      m_lvl <= 7; m_gid <= 0; m_acc <= 0; m_err <= 0; m_rd <= 0;
    end else begin
      bl = 7; bg = 0;
      for (int g = FG; g < NG; g++)
        if (is_cand(g) && int'(lv[g]) < bl) begin bl = int'(lv[g]); bg = g; end
      rdv = 0;
      if (bus_rd && bus_addr == 0 && is_cand(m_acc)) rdv = m_acc * 4;
      m_rd <= rdv;
      if (ack_valid) begin
        m_acc <= m_gid;
        if (int'(ack_level) != m_lvl) m_err <= 1;
      end
      m_lvl <= bl; m_gid <= bg;
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Every-cycle comparison against the reference, away from the edge
  always @(negedge clk) if (!rst && !done) begin
    chk("R3/R4 irq_level vs model", int'(irq_level), m_lvl);
    chk("R6 level_err vs model", int'(level_err), m_err);
    chk("R7/R8 bus_rdata vs model", int'(bus_rdata), m_rd);
  end

  task automatic clear_all();
    for (int g = 0; g < NG; g++) begin rq[g] = 0; en[g] = 4'hF; lv[g] = 3'd7; end
  endtask

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_read(int a);
    bus_rd = 1; bus_addr = AW'(a); tick(); bus_rd = 0;
  endtask

  task automatic do_ack(int l);
    ack_valid = 1; ack_level = 3'(l); tick(); ack_valid = 0;
  endtask

  initial begin
    clear_all();
    tick(3);
    rst = 0;
    // R10: reset values
    chk("R10 reset irq_level", int'(irq_level), 7);
    chk("R10 reset level_err", int'(level_err), 0);
    chk("R10 reset bus_rdata", int'(bus_rdata), 0);
    do_read(0);
    chk("R10 accepted group after reset reads 0", int'(bus_rdata), 0);

    // R1: groups 0 and 1 ignored
    rq[0] = 4'hF; lv[0] = 0; rq[1] = 4'h1; lv[1] = 1;
    tick(2);
    chk("R1 groups 0/1 ignored", int'(irq_level), 7);

    // R2: request without enable is not a candidate
    rq[6] = 4'b0100; en[6] = 4'b0011; lv[6] = 3;
    tick(2);
    chk("R2 masked request ignored", int'(irq_level), 7);

    // R4: registered, one cycle latency
    en[6] = 4'b0100;
    chk("R4 level not yet updated", int'(irq_level), 7);
    tick();
    chk("R4 level after one edge", int'(irq_level), 3);

    // R3: tie goes to lowest group; level 7 candidate never wins
    rq[9] = 1; lv[9] = 2; rq[4] = 2; lv[4] = 2; rq[3] = 1; lv[3] = 7;
    tick();
    chk("R3 tie lowest group level", int'(irq_level), 2);

    // R5 / R7: ack latches group 4, read gives 16
    do_ack(2);
    do_read(0);
    chk("R7 accepted group readback", int'(bus_rdata), 16);
    chk("R6 matching ack leaves flag clear", int'(level_err), 0);

    // R9: writes ignored
    bus_wr = 1; bus_wdata = 8'hFF; bus_addr = 0; tick(); bus_wr = 0;
    do_read(0);
    chk("R9 write ignored", int'(bus_rdata), 16);

    // R8: other offset zero; lost request reads zero
    do_read(1);
    chk("R8 nonzero offset reads 0", int'(bus_rdata), 0);
    rq[4] = 0;
    tick();
    do_read(0);
    chk("R8 lost request reads 0", int'(bus_rdata), 0);
    chk("R5 new winner after loss", int'(irq_level), 2);

    // R3: only level-7 candidate -> idle, ack latches group 0
    rq[9] = 0; rq[6] = 0;
    tick(2);
    chk("R3 level-7 candidate gives idle", int'(irq_level), 7);
    do_ack(7);
    do_read(0);
    chk("R5 idle ack latches group 0", int'(bus_rdata), 0);

    // R6: mismatch sets sticky flag
    do_ack(5);
    chk("R6 mismatch sets flag", int'(level_err), 1);
    tick(3);
    chk("R6 flag sticky", int'(level_err), 1);

    // Random phase with periodic resets
    for (int it = 0; it < 1500; it++) begin
      if (it % 500 == 250) begin
        rst = 1; tick(); rst = 0;
      end
      for (int g = 0; g < NG; g++) begin
        if ($urandom_range(0, 7) == 0) rq[g] = 4'($urandom_range(0, 15)) & 4'($urandom_range(0, 15));
        if ($urandom_range(0, 15) == 0) en[g] = 4'($urandom_range(0, 15));
        if ($urandom_range(0, 15) == 0) lv[g] = 3'($urandom_range(0, 7));
      end
      ack_valid = ($urandom_range(0, 3) == 0);
      ack_level = ($urandom_range(0, 15) == 0) ? irq_level ^ 3'd1 : irq_level;
      bus_rd    = ($urandom_range(0, 1) == 0);
      bus_wr    = ($urandom_range(0, 3) == 0);
      bus_addr  = ($urandom_range(0, 3) == 0) ? AW'($urandom_range(1, 7)) : '0;
      bus_wdata = 8'($urandom_range(0, 255));
      tick();
    end
    ack_valid = 0; bus_rd = 0; bus_wr = 0;
    tick(2);
    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(5ns * 100000);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule